// File: doc/BRIEF.md
# Rank Power-State Timing Sequencer

This block spaces the events around leaving reset, entering and leaving self-refresh, and impedance calibration on one DDR3 rank. The memory controller raises single-cycle requests: leave reset, enter self-refresh, leave self-refresh, long calibration and short calibration. The sequencer drives the clock-enable pin. It raises a flag when the controller may stop the memory clock. It also drives two ready flags. One is for commands that can run without a locked DLL, and the other is for commands that need a locked DLL.

Each wait is a clock count derived at elaboration from parameters: the clock period in picoseconds, the refresh cycle time, the minimum clock-enable width, the DLL lock time and the three calibration lengths. A request that arrives while an interval runs is held and served when the sequencer reaches its idle phase. A request that cannot apply to the current phase is discarded.

Top module: `rank_pwr_seq`

## Requirements
- R1: After reset, cke=0, clk_stop_ok=0, rdy_nodll=0, rdy_dll=0 and cal_rdy=1, and clk_stop_ok is never high while cke is high.
- R2: An accepted reset-exit request drives cke high after the accepting edge. rdy_nodll and rdy_dll rise XS edges later, where XS = max(5, ceil((tRFC_ps + 10000) / clk_ps)).
- R3: An accepted self-refresh entry drops cke after the accepting edge. clk_stop_ok rises CKV edges later, where CKV = max(5, ceil(10000 / clk_ps)).
- R4: An accepted self-refresh exit drops clk_stop_ok after the accepting edge. cke stays low for CKV more edges and then rises.
- R5: An exit is accepted only once cke has been low for at least TCKE_MIN_CK+1 cycles. An earlier exit request is held, and an exit request made after that point is taken on the next edge.
- R6: After an exit, rdy_nodll rises XS edges after cke rises, and rdy_dll rises DLL_LOCK_CK edges after cke rises.
- R7: cal_rdy is low for exactly L cycles from the accepting edge and then returns high. L is ZQ_INIT_CK for the first long calibration after reset exit, ZQ_LONG_CK for later long calibrations and ZQ_SHORT_CK for a short one.
- R8: rdy_nodll is low whenever cal_rdy is low, and rdy_dll is never high without rdy_nodll.
- R9: Requests made during a running interval are held. From idle with the DLL locked, they are served one per idle cycle, with long calibration first, then short calibration, then self-refresh entry.
- R10: A request that does not apply to the current phase is discarded and has no later effect. This covers entry or calibration during reset or self-refresh, exit outside self-refresh, and reset exit after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_exit_req | input | 1 | Request to leave reset (raise clock enable) |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| zq_long_req | input | 1 | Request a long calibration |
| zq_short_req | input | 1 | Request a short calibration |
| cke | output | 1 | Clock-enable drive to the rank |
| clk_stop_ok | output | 1 | Memory clock may be stopped |
| rdy_nodll | output | 1 | Commands not needing a locked DLL may issue |
| rdy_dll | output | 1 | Commands needing a locked DLL may issue |
| cal_rdy | output | 1 | No calibration running |

## Verification
A request is taken on the rising edge where it is seen. cke and clk_stop_ok change right after that edge. Every later flag moves a whole number of edges after it: XS, CKV, L or DLL_LOCK_CK edges, plus one extra idle edge before a held request is taken. The bench drives at falling edges and computes each count from the clock period and timing parameters. For each boundary it samples one falling edge before the expected change and the falling edge just after it, so an off-by-one in either direction is caught.

// File: rtl/rank_pwr_pkg.sv
`timescale 1ns/1ps
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RESET, ST_XPR, ST_IDLE, ST_SRE_CLK,
    ST_SELF, ST_SRX_CLK, ST_SRX, ST_CAL
  } seq_state_e;

  localparam int REQ_RST = 0;
  localparam int REQ_SRE = 1;
  localparam int REQ_SRX = 2;
  localparam int REQ_ZQL = 3;
  localparam int REQ_ZQS = 4;
  localparam int NUM_REQ = 5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // larger of a clock floor and a time span rounded up to clocks
  function automatic int span_ck(input int ps, input int clk_ps, input int floor_ck);
    return imax(floor_ck, cdiv(ps, clk_ps));
  endfunction

endpackage

// File: rtl/rank_pwr_timer.sv
`timescale 1ns/1ps
module rank_pwr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rank_pwr_hold.sv
`timescale 1ns/1ps
module rank_pwr_hold #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] keep,
  input  logic [N-1:0] take,
  output logic [N-1:0] live
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q | req[i]) & keep[i] & ~take[i];
    end
    assign live[i] = pend_q | req[i];
  end
endmodule

// File: rtl/rank_pwr_seq.sv
`timescale 1ns/1ps
module rank_pwr_seq
  import rank_pwr_pkg::*;
#(
  parameter int CLK_PS      = 1500,
  parameter int TRFC_PS     = 110000,
  parameter int TCKE_MIN_CK = 4,
  parameter int DLL_LOCK_CK = 512,
  parameter int ZQ_INIT_CK  = 512,
  parameter int ZQ_LONG_CK  = 256,
  parameter int ZQ_SHORT_CK = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_exit_req,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  input  logic zq_long_req,
  input  logic zq_short_req,
  output logic cke,
  output logic clk_stop_ok,
  output logic rdy_nodll,
  output logic rdy_dll,
  output logic cal_rdy
);
  localparam int XS_CK    = span_ck(TRFC_PS + 10000, CLK_PS, 5);
  localparam int CKVAL_CK = span_ck(10000, CLK_PS, 5);
  localparam int CKESR_CK = TCKE_MIN_CK + 1;
  localparam int MAX_CK   = imax(imax(XS_CK, CKVAL_CK),
                                 imax(ZQ_INIT_CK, imax(ZQ_LONG_CK, ZQ_SHORT_CK)));
  localparam int TW = $clog2(MAX_CK + 1);
  localparam int DW = $clog2(DLL_LOCK_CK + 1);
  localparam int LW = $clog2(CKESR_CK + 1);

  seq_state_e state_q, state_d;
  logic [NUM_REQ-1:0] req_vec, keep, take, live;
  logic          tmr_load, tmr_done, dll_load, dll_done;
  logic [TW-1:0] tmr_val;
  logic [LW-1:0] low_q;
  logic          zq_first_q;

  // named internal events, observed by the checker
  logic acc_rst, acc_sre, acc_srx, acc_zql, acc_zqs;
  logic idle_go, low_met, cke_on, cke_up;

  assign req_vec[REQ_RST] = rst_exit_req;
  assign req_vec[REQ_SRE] = sr_enter_req;
  assign req_vec[REQ_SRX] = sr_exit_req;
  assign req_vec[REQ_ZQL] = zq_long_req;
  assign req_vec[REQ_ZQS] = zq_short_req;

  assign cke_on  = (state_q == ST_XPR) || (state_q == ST_IDLE) ||
                   (state_q == ST_SRX) || (state_q == ST_CAL);
  assign idle_go = (state_q == ST_IDLE) && dll_done;
  assign low_met = (32'(low_q) >= CKESR_CK);

  assign acc_rst = (state_q == ST_RESET) && live[REQ_RST];
  assign acc_zql = idle_go && live[REQ_ZQL];
  assign acc_zqs = idle_go && !live[REQ_ZQL] && live[REQ_ZQS];
  assign acc_sre = idle_go && !live[REQ_ZQL] && !live[REQ_ZQS] && live[REQ_SRE];
  assign acc_srx = (state_q == ST_SELF) && low_met && live[REQ_SRX];
  assign cke_up  = (state_q == ST_SRX_CLK) && tmr_done;

  assign keep[REQ_RST] = (state_q == ST_RESET);
  assign keep[REQ_SRE] = cke_on;
  assign keep[REQ_ZQL] = cke_on;
  assign keep[REQ_ZQS] = cke_on;
  assign keep[REQ_SRX] = (state_q == ST_SRE_CLK) || (state_q == ST_SELF);

  assign take[REQ_RST] = acc_rst;
  assign take[REQ_SRE] = acc_sre;
  assign take[REQ_SRX] = acc_srx;
  assign take[REQ_ZQL] = acc_zql;
  assign take[REQ_ZQS] = acc_zqs;

  rank_pwr_hold #(.N(NUM_REQ)) u_hold (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .keep(keep), .take(take), .live(live)
  );

  rank_pwr_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  assign dll_load = cke_up;
  rank_pwr_timer #(.W(DW)) u_dll (
    .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(DW'(DLL_LOCK_CK)),
    .expired(dll_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_RESET: if (acc_rst) begin
        state_d = ST_XPR; tmr_load = 1'b1; tmr_val = TW'(XS_CK - 1);
      end
      ST_XPR:     if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (acc_zql) begin
          state_d  = ST_CAL; tmr_load = 1'b1;
          tmr_val  = zq_first_q ? TW'(ZQ_INIT_CK - 1) : TW'(ZQ_LONG_CK - 1);
        end else if (acc_zqs) begin
          state_d = ST_CAL; tmr_load = 1'b1; tmr_val = TW'(ZQ_SHORT_CK - 1);
        end else if (acc_sre) begin
          state_d = ST_SRE_CLK; tmr_load = 1'b1; tmr_val = TW'(CKVAL_CK - 1);
        end
      end
      ST_SRE_CLK: if (tmr_done) state_d = ST_SELF;
      ST_SELF: if (acc_srx) begin
        state_d = ST_SRX_CLK; tmr_load = 1'b1; tmr_val = TW'(CKVAL_CK - 1);
      end
      ST_SRX_CLK: if (tmr_done) begin
        state_d = ST_SRX; tmr_load = 1'b1; tmr_val = TW'(XS_CK - 1);
      end
      ST_SRX:     if (tmr_done) state_d = ST_IDLE;
      ST_CAL:     if (tmr_done) state_d = ST_IDLE;
      default:    state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_RESET;
      low_q      <= '0;
      zq_first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_sre)
        low_q <= '0;
      else if (((state_q == ST_SRE_CLK) || (state_q == ST_SELF)) && !low_met)
        low_q <= low_q + LW'(1);
      if (acc_rst)      zq_first_q <= 1'b1;
      else if (acc_zql) zq_first_q <= 1'b0;
    end
  end

  assign cke         = cke_on;
  assign clk_stop_ok = (state_q == ST_SELF);
  assign rdy_nodll   = (state_q == ST_IDLE);
  assign rdy_dll     = (state_q == ST_IDLE) && dll_done;
  assign cal_rdy     = (state_q != ST_CAL);
endmodule

// File: rtl/rank_pwr_seq_chk.sv
`timescale 1ns/1ps
module rank_pwr_seq_chk #(
  parameter int CKESR = 5,
  parameter int CKVAL = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic clk_stop_ok,
  input logic rdy_nodll,
  input logic rdy_dll,
  input logic cal_rdy,
  input logic acc_rst,
  input logic acc_sre,
  input logic acc_srx,
  input logic acc_zql,
  input logic acc_zqs
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || cke)         low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
  end

  a_r1_stop_only_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_ok |-> !cke);
  a_r3_entry_drops_cke: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sre |=> (!cke && !clk_stop_ok));
  a_r3_clock_kept_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_ok |-> (low_run >= 16'(CKVAL)));
  a_r4_exit_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
    acc_srx |=> (!clk_stop_ok && !cke));
  a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    acc_srx |-> (low_run >= 16'(CKESR)));
  a_r8_dll_needs_nodll: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_dll |-> rdy_nodll);
  a_r8_cal_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_rdy |-> !rdy_nodll);
  a_r9_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_rst, acc_sre, acc_srx, acc_zql, acc_zqs}));
endmodule

bind rank_pwr_seq rank_pwr_seq_chk #(.CKESR(CKESR_CK), .CKVAL(CKVAL_CK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .clk_stop_ok(clk_stop_ok),
  .rdy_nodll(rdy_nodll), .rdy_dll(rdy_dll), .cal_rdy(cal_rdy),
  .acc_rst(acc_rst), .acc_sre(acc_sre), .acc_srx(acc_srx),
  .acc_zql(acc_zql), .acc_zqs(acc_zqs)
);

// File: tb/rank_pwr_seq_bench.sv
`timescale 1ns/1ps
module rank_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_CLK_PS   = 1500;
  localparam int P_TRFC_PS  = 110000;
  localparam int P_TCKE     = 12;
  localparam int P_DLL      = 512;
  localparam int P_ZQI      = 512;
  localparam int P_ZQL      = 256;
  localparam int P_ZQS      = 64;

  // expected counts, worked out from the requirement formulas
  localparam int XS   = ((P_TRFC_PS + 10000 + P_CLK_PS - 1) / P_CLK_PS > 5) ?
                        (P_TRFC_PS + 10000 + P_CLK_PS - 1) / P_CLK_PS : 5;   // 80
  localparam int CKV  = ((10000 + P_CLK_PS - 1) / P_CLK_PS > 5) ?
                        (10000 + P_CLK_PS - 1) / P_CLK_PS : 5;               // 7
  localparam int ESR  = P_TCKE + 1;                                          // 13

  localparam logic [4:0] M_RST = 5'b00001;
  localparam logic [4:0] M_SRE = 5'b00010;
  localparam logic [4:0] M_SRX = 5'b00100;
  localparam logic [4:0] M_ZQL = 5'b01000;
  localparam logic [4:0] M_ZQS = 5'b10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] req = '0;
  logic cke, clk_stop_ok, rdy_nodll, rdy_dll, cal_rdy;
  int checks = 0;
  int fails = 0;
  int viol = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rank_pwr_seq #(
    .CLK_PS(P_CLK_PS), .TRFC_PS(P_TRFC_PS), .TCKE_MIN_CK(P_TCKE),
    .DLL_LOCK_CK(P_DLL), .ZQ_INIT_CK(P_ZQI), .ZQ_LONG_CK(P_ZQL), .ZQ_SHORT_CK(P_ZQS)
  ) u_rank_pwr_seq (
    .clk(clk), .rst_n(rst_n),
    .rst_exit_req(req[0]), .sr_enter_req(req[1]), .sr_exit_req(req[2]),
    .zq_long_req(req[3]), .zq_short_req(req[4]),
    .cke(cke), .clk_stop_ok(clk_stop_ok), .rdy_nodll(rdy_nodll),
    .rdy_dll(rdy_dll), .cal_rdy(cal_rdy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic [4:0] m);
    req = m;
    @(posedge clk);
    @(negedge clk);
    req = '0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // R8 and R1 invariants watched every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_dll && !rdy_nodll) viol++;
      if (!cal_rdy && rdy_nodll) viol++;
      if (clk_stop_ok && cke)    viol++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    chk("R1 cke", cke, 1'b0);
    chk("R1 clk_stop_ok", clk_stop_ok, 1'b0);
    chk("R1 rdy_nodll", rdy_nodll, 1'b0);
    chk("R1 rdy_dll", rdy_dll, 1'b0);
    chk("R1 cal_rdy", cal_rdy, 1'b1);

    // R10 entry during reset is discarded
    pulse(M_SRE);
    chk("R10 cke stays low", cke, 1'b0);

    // R2 reset exit
    pulse(M_RST);
    chk("R2 cke up", cke, 1'b1);
    pulse(M_ZQS);                       // R9 held through the exit interval
    waitn(XS - 2);
    chk("R2 rdy_nodll early", rdy_nodll, 1'b0);
    waitn(1);
    chk("R2 rdy_nodll due", rdy_nodll, 1'b1);
    chk("R2 rdy_dll due", rdy_dll, 1'b1);
    waitn(1);
    chk("R9 held short cal taken", cal_rdy, 1'b0);
    waitn(P_ZQS - 1);
    chk("R7 short cal still busy", cal_rdy, 1'b0);
    waitn(1);
    chk("R7 short cal done", cal_rdy, 1'b1);
    chk("R8 ready after cal", rdy_nodll, 1'b1);
    waitn(1);
    chk("R10 no stale entry", cke, 1'b1);

    // R7 first long uses init length, next uses long length
    pulse(M_ZQL);
    chk("R7 init cal start", cal_rdy, 1'b0);
    waitn(P_ZQI - 1);
    chk("R7 init cal busy", cal_rdy, 1'b0);
    waitn(1);
    chk("R7 init cal done", cal_rdy, 1'b1);
    pulse(M_ZQL);
    waitn(P_ZQL - 1);
    chk("R7 long cal busy", cal_rdy, 1'b0);
    waitn(1);
    chk("R7 long cal done", cal_rdy, 1'b1);

    // R9 priority: long, then short, then entry
    pulse(M_ZQL | M_ZQS | M_SRE);
    chk("R9 long first", cal_rdy, 1'b0);
    chk("R9 cke during long", cke, 1'b1);
    waitn(P_ZQL - 1);
    waitn(1);
    chk("R9 idle between", cal_rdy, 1'b1);
    waitn(1);
    chk("R9 short second", cal_rdy, 1'b0);
    waitn(P_ZQS - 1);
    waitn(1);
    chk("R9 short done", cal_rdy, 1'b1);
    chk("R9 cke before entry", cke, 1'b1);
    waitn(1);
    chk("R9 entry third", cke, 1'b0);

    // R3 / R5 / R4: exit requested right away is held
    pulse(M_SRX);
    waitn(CKV - 2);
    chk("R3 stop early", clk_stop_ok, 1'b0);
    waitn(1);
    chk("R3 stop due", clk_stop_ok, 1'b1);
    waitn(ESR - CKV);
    chk("R5 exit held", clk_stop_ok, 1'b1);
    waitn(1);
    chk("R4 stop dropped", clk_stop_ok, 1'b0);
    chk("R4 cke still low", cke, 1'b0);
    waitn(CKV - 1);
    chk("R4 cke low before", cke, 1'b0);
    waitn(1);
    chk("R4 cke up", cke, 1'b1);
    waitn(XS - 1);
    chk("R6 nodll early", rdy_nodll, 1'b0);
    waitn(1);
    chk("R6 nodll due", rdy_nodll, 1'b1);
    chk("R6 dll not yet", rdy_dll, 1'b0);
    waitn(P_DLL - XS - 1);
    chk("R6 dll early", rdy_dll, 1'b0);
    waitn(1);
    chk("R6 dll due", rdy_dll, 1'b1);

    // R10 exit outside self-refresh is discarded
    pulse(M_SRX);
    chk("R10 cke unaffected", cke, 1'b1);
    pulse(M_SRE);
    chk("R3 entry", cke, 1'b0);
    waitn(40);
    chk("R10 still in self-refresh", cke, 1'b0);
    chk("R10 stop still high", clk_stop_ok, 1'b1);
    pulse(M_SRX);
    chk("R5 late exit taken at once", clk_stop_ok, 1'b0);
    waitn(CKV - 1);
    chk("R4 cke low before second", cke, 1'b0);
    waitn(1);
    chk("R4 cke up second", cke, 1'b1);
    waitn(P_DLL);
    chk("R6 dll ready second", rdy_dll, 1'b1);

    checks++;
    if (viol != 0) begin
      fails++;
      $display("FAIL R8 invariant violations actual=%0d expected=0", viol);
    end
    finish_run();
  end
endmodule